// File: doc/BRIEF.md
# Interrupt Recognition Shadow Controller

This block runs the end-of-instruction sequence of an x86-style execution unit and decides, at every instruction boundary, whether a pending maskable interrupt is taken or the unit simply fetches the next instruction. When the decoder signals that an instruction has finished, the controller waits a fixed number of clocks and asks the bus unit for the next opcode. It then holds while the prefetch queue is empty, clears the prefix state, and finally polls the interrupt request line.

Two mechanisms shape the poll. The first is a one-instruction recognition shadow. It is set only by instructions that reload the stack segment or set the interrupt-enable flag, so that a stack reload stays atomic. The second is a delayed copy of the interrupt-enable flag. This copy normally follows the architectural flag only at instruction boundaries. A flags reload done by an interrupt return is the exception: it lands in the delayed copy in the same cycle, so an interrupt that is already pending is taken right after the return.

Top module: `irq_shadow_ctl`

## Requirements
- R1: An end strobe accepted while idle starts a wait of exactly 12 clocks. After the wait, `fetch_req` is high for exactly one clock.
- R2: In the clock after the fetch request, the controller stays in the queue wait for as long as bit 7 (value 0x80) of `pfq_status` is 1; the other status bits have no effect. Once bit 7 reads 0, `prefix_clr` is high for one clock, and the poll follows in the next clock.
- R3: In the poll clock, `take_int` is high for exactly one clock if `intr_req` is 1, the delayed enable is 1 and no shadow is active. Otherwise `cont_fetch` is high for exactly one clock. Each accepted end strobe produces exactly one of the two.
- R4: An instruction of class 1 (stack-segment load, by move or pop) suppresses the poll at its own boundary, which then gives `cont_fetch`. The next boundary polls normally.
- R5: An instruction of class 3 (enable-interrupts) shadows its boundary in the same way. Back-to-back shadowing instructions each shadow only their own boundary.
- R6: Class 2 (loads of the other segment registers), class 4 (interrupt return), class 0 and the unused codes 5 to 7 never shadow.
- R7: The delayed enable takes the value of `flags_if` in each poll clock and holds it until the next one. A change of `flags_if` in between has no effect on the boundary that follows.
- R8: A flags write (`flags_wr`) made while `insn_class` is 4 loads the delayed enable from bit 9 of `flags_wdata` in that same clock. A flags write under any other class leaves the delayed enable unchanged.
- R9: An end strobe that arrives while an end sequence is in progress is ignored and does not change its timing.
- R10: After reset, the controller is idle with all outputs low, the delayed enable 0 and no shadow active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_end | input | 1 | Instruction-complete strobe from the execution unit |
| insn_class | input | 3 | Class of the current instruction: 0 other, 1 stack-segment load, 2 other segment load, 3 enable-interrupts, 4 interrupt return |
| flags_if | input | 1 | Architectural interrupt-enable flag |
| flags_wr | input | 1 | Flags-word write strobe |
| flags_wdata | input | 16 | Flags word being written; bit 9 is the interrupt enable |
| pfq_status | input | 8 | Prefetch-queue status; bit 7 set means empty |
| intr_req | input | 1 | Maskable interrupt request |
| fetch_req | output | 1 | One-clock opcode-fetch request to the bus unit |
| prefix_clr | output | 1 | One-clock pulse that clears the prefix flags |
| take_int | output | 1 | One-clock pulse: the interrupt is taken at this boundary |
| cont_fetch | output | 1 | One-clock pulse: execution continues with the next instruction |

## Verification
The checker watches on every cycle that the poll pulses are single-clock and mutually exclusive, and that a take only coincides with a request. It also checks that every poll is directly preceded by a prefix clear, that a prefix clear only follows a non-empty queue status, and that no interrupt is taken at a boundary whose instruction class shadows it. The bench's scenarios alone show the exact 12-clock wait, the timing of the queue stall, the delayed update of the enable across boundaries, the same-cycle reload on interrupt return as against other flags writes, and that a strobe arriving while busy is ignored.

// File: rtl/isc_pkg.sv
package isc_pkg;

    localparam int CLASS_W = 3;

    typedef enum logic [CLASS_W-1:0] {
        CLS_OTHER   = 3'd0,
        CLS_SS_LOAD = 3'd1,
        CLS_SEG     = 3'd2,
        CLS_STI     = 3'd3,
        CLS_IRET    = 3'd4
    } insn_class_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_FETCH,
        ST_PFQ,
        ST_CLR,
        ST_POLL
    } seq_state_e;

    typedef struct packed {
        logic fetch_req;
        logic prefix_clr;
        logic take_int;
        logic cont_fetch;
    } seq_out_t;

    function automatic logic class_shadows(input logic [CLASS_W-1:0] cls);
        return (cls == CLS_SS_LOAD) || (cls == CLS_STI);
    endfunction

    function automatic logic class_is_iret(input logic [CLASS_W-1:0] cls);
        return cls == CLS_IRET;
    endfunction

endpackage

// File: rtl/isc_wait_timer.sv
module isc_wait_timer #(
    parameter int WAIT_CLKS = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic done
);
    localparam int CNT_W = (WAIT_CLKS > 1) ? $clog2(WAIT_CLKS) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAIT_CLKS - 1);

    logic [CNT_W-1:0] cnt;
    logic             running;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (start) begin
            cnt     <= LOAD_VAL;
            running <= 1'b1;
        end else if (running) begin
            if (cnt == '0) begin
                running <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign done = running && (cnt == '0);
endmodule

// File: rtl/isc_enable_track.sv
module isc_enable_track
    import isc_pkg::*;
#(
    parameter int FLAGS_W = 16,
    parameter int IE_BIT  = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               accept,
    input  logic               boundary,
    input  logic [CLASS_W-1:0] cls,
    input  logic               flags_if,
    input  logic               flags_wr,
    input  logic [FLAGS_W-1:0] flags_wdata,
    output logic               ie_dly,
    output logic               shadow
);
    logic iret_reload;

    assign iret_reload = flags_wr && class_is_iret(cls);

    // Delayed enable: same-cycle reload on interrupt return, else boundary copy
    always_ff @(posedge clk) begin
        if (rst) begin
            ie_dly <= 1'b0;
        end else if (iret_reload) begin
            ie_dly <= flags_wdata[IE_BIT];
        end else if (boundary) begin
            ie_dly <= flags_if;
        end
    end

    // Shadow belongs to the boundary of the instruction that set it
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= 1'b0;
        end else if (accept) begin
            shadow <= class_shadows(cls);
        end else if (boundary) begin
            shadow <= 1'b0;
        end
    end
endmodule

// File: rtl/isc_seq.sv
module isc_seq
    import isc_pkg::*;
#(
    parameter int PFQ_W     = 8,
    parameter int EMPTY_BIT = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             insn_end,
    input  logic             wait_done,
    input  logic [PFQ_W-1:0] pfq_status,
    input  logic             intr_req,
    input  logic             ie_dly,
    input  logic             shadow,
    output logic             accept,
    output logic             boundary,
    output seq_out_t         outs
);
    localparam logic [PFQ_W-1:0] EMPTY_MASK = PFQ_W'(1) << EMPTY_BIT;

    seq_state_e state, nxt;
    logic       pfq_empty;

    assign pfq_empty = (pfq_status & EMPTY_MASK) != '0;
    assign accept    = (state == ST_IDLE) && insn_end;
    assign boundary  = (state == ST_POLL);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (insn_end)  nxt = ST_WAIT;
            ST_WAIT:  if (wait_done) nxt = ST_FETCH;
            ST_FETCH: nxt = ST_PFQ;
            ST_PFQ:   if (!pfq_empty) nxt = ST_CLR;
            ST_CLR:   nxt = ST_POLL;
            ST_POLL:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        outs            = '0;
        outs.fetch_req  = (state == ST_FETCH);
        outs.prefix_clr = (state == ST_CLR);
        if (state == ST_POLL) begin
            if (!shadow && ie_dly && intr_req) outs.take_int   = 1'b1;
            else                               outs.cont_fetch = 1'b1;
        end
    end
endmodule

// File: rtl/irq_shadow_ctl.sv
module irq_shadow_ctl
    import isc_pkg::*;
#(
    parameter int WAIT_CLKS = 12,
    parameter int FLAGS_W   = 16,
    parameter int IE_BIT    = 9,
    parameter int PFQ_W     = 8,
    parameter int EMPTY_BIT = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               insn_end,
    input  logic [CLASS_W-1:0] insn_class,
    input  logic               flags_if,
    input  logic               flags_wr,
    input  logic [FLAGS_W-1:0] flags_wdata,
    input  logic [PFQ_W-1:0]   pfq_status,
    input  logic               intr_req,
    output logic               fetch_req,
    output logic               prefix_clr,
    output logic               take_int,
    output logic               cont_fetch
);
    logic     accept, boundary, wait_done, ie_dly, shadow;
    seq_out_t outs;

    isc_wait_timer #(.WAIT_CLKS(WAIT_CLKS)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .done  (wait_done)
    );

    isc_enable_track #(.FLAGS_W(FLAGS_W), .IE_BIT(IE_BIT)) u_track (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .boundary    (boundary),
        .cls         (insn_class),
        .flags_if    (flags_if),
        .flags_wr    (flags_wr),
        .flags_wdata (flags_wdata),
        .ie_dly      (ie_dly),
        .shadow      (shadow)
    );

    isc_seq #(.PFQ_W(PFQ_W), .EMPTY_BIT(EMPTY_BIT)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .insn_end   (insn_end),
        .wait_done  (wait_done),
        .pfq_status (pfq_status),
        .intr_req   (intr_req),
        .ie_dly     (ie_dly),
        .shadow     (shadow),
        .accept     (accept),
        .boundary   (boundary),
        .outs       (outs)
    );

    assign fetch_req  = outs.fetch_req;
    assign prefix_clr = outs.prefix_clr;
    assign take_int   = outs.take_int;
    assign cont_fetch = outs.cont_fetch;
endmodule

// File: rtl/irq_shadow_ctl_chk.sv
module irq_shadow_ctl_chk
    import isc_pkg::*;
#(
    parameter int PFQ_W     = 8,
    parameter int EMPTY_BIT = 7
) (
    input logic               clk,
    input logic               rst,
    input logic               insn_end,
    input logic [CLASS_W-1:0] insn_class,
    input logic [PFQ_W-1:0]   pfq_status,
    input logic               intr_req,
    input logic               fetch_req,
    input logic               prefix_clr,
    input logic               take_int,
    input logic               cont_fetch
);
    // Observer's own view of the instruction whose boundary is pending
    logic busy_q;
    logic shadow_cls_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q       <= 1'b0;
            shadow_cls_q <= 1'b0;
        end else if (!busy_q && insn_end) begin
            busy_q       <= 1'b1;
            shadow_cls_q <= (insn_class == CLS_SS_LOAD) || (insn_class == CLS_STI);
        end else if (take_int || cont_fetch) begin
            busy_q <= 1'b0;
        end
    end

    p_one_result_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fetch_req, prefix_clr, take_int, cont_fetch}));

    p_take_single_r3: assert property (@(posedge clk) disable iff (rst)
        take_int |=> !take_int);

    p_take_needs_req_r3: assert property (@(posedge clk) disable iff (rst)
        take_int |-> intr_req);

    p_fetch_single_r1: assert property (@(posedge clk) disable iff (rst)
        fetch_req |=> !fetch_req);

    p_clr_before_poll_r2: assert property (@(posedge clk) disable iff (rst)
        (take_int || cont_fetch) |-> $past(prefix_clr));

    p_clr_after_queue_r2: assert property (@(posedge clk) disable iff (rst)
        prefix_clr |-> !$past(pfq_status[EMPTY_BIT]));

    p_no_take_in_shadow_r4: assert property (@(posedge clk) disable iff (rst)
        (busy_q && shadow_cls_q) |-> !take_int);

    p_result_only_when_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (take_int || cont_fetch) |-> busy_q);
endmodule

bind irq_shadow_ctl irq_shadow_ctl_chk #(.PFQ_W(PFQ_W), .EMPTY_BIT(EMPTY_BIT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .insn_end   (insn_end),
    .insn_class (insn_class),
    .pfq_status (pfq_status),
    .intr_req   (intr_req),
    .fetch_req  (fetch_req),
    .prefix_clr (prefix_clr),
    .take_int   (take_int),
    .cont_fetch (cont_fetch)
);

// File: tb/sim_irq_shadow_ctl.sv
module sim_irq_shadow_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int EV_FETCH = 1, EV_CLR = 2, EV_TAKE = 3, EV_CONT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        insn_end = 1'b0;
    logic [2:0]  insn_class = 3'd0;
    logic        flags_if = 1'b0;
    logic        flags_wr = 1'b0;
    logic [15:0] flags_wdata = 16'h0;
    logic [7:0]  pfq_status = 8'h00;
    logic        intr_req = 1'b0;
    logic        fetch_req, prefix_clr, take_int, cont_fetch;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int     q_code[$];
    int     q_cyc[$];
    string  q_req[$];

    irq_shadow_ctl u0 (
        .clk(clk), .rst(rst), .insn_end(insn_end), .insn_class(insn_class),
        .flags_if(flags_if), .flags_wr(flags_wr), .flags_wdata(flags_wdata),
        .pfq_status(pfq_status), .intr_req(intr_req),
        .fetch_req(fetch_req), .prefix_clr(prefix_clr),
        .take_int(take_int), .cont_fetch(cont_fetch)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic expect_ev(input int code, input int at, input string req);
        q_code.push_back(code);
        q_cyc.push_back(at);
        q_req.push_back(req);
    endtask

    // Monitor: every pulse seen must match the front of the scoreboard
    task automatic observe(input int code);
        if (q_code.size() == 0) begin
            check(1'b0, "R3 unexpected pulse", code, 0);
        end else begin
            int    ec  = q_code.pop_front();
            int    et  = q_cyc.pop_front();
            string req = q_req.pop_front();
            check(ec == code, req, code, ec);
            check(et == cyc, {req, " timing"}, cyc, et);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (fetch_req)  observe(EV_FETCH);
            if (prefix_clr) observe(EV_CLR);
            if (take_int)   observe(EV_TAKE);
            if (cont_fetch) observe(EV_CONT);
        end
    end

    // Driver: one instruction end, with optional flags write and late strobe
    task automatic run_insn(input int cls, input int n_empty, input bit intr,
                            input bit do_wr, input logic [15:0] wdata,
                            input bit extra_strobe, input bit exp_take,
                            input string req);
        int c0;
        @(negedge clk);
        insn_class = cls[2:0];
        intr_req   = intr;
        pfq_status = (n_empty > 0) ? 8'h80 : 8'h7F;
        if (do_wr) begin
            flags_wr    = 1'b1;
            flags_wdata = wdata;
            @(negedge clk);
            flags_wr = 1'b0;
            flags_if = wdata[9];
        end
        c0 = cyc;
        insn_end = 1'b1;
        expect_ev(EV_FETCH, c0 + 13, "R1 fetch after 12-clock wait");
        expect_ev(EV_CLR, c0 + 15 + n_empty, "R2 prefix clear after queue wait");
        expect_ev(exp_take ? EV_TAKE : EV_CONT, c0 + 16 + n_empty, req);
        @(negedge clk);
        insn_end = 1'b0;
        while (cyc < c0 + 17 + n_empty) begin
            @(negedge clk);
            if (extra_strobe && cyc == c0 + 5) insn_end = 1'b1;
            else insn_end = 1'b0;
            if (cyc == c0 + 14 + n_empty) pfq_status = 8'h7F;
        end
        insn_end = 1'b0;
        check(q_code.size() == 0, {req, " all pulses seen"}, q_code.size(), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        check(1'b0, "watchdog", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: idle outputs after reset
        repeat (2) @(negedge clk);
        check(fetch_req == 1'b0, "R10 fetch_req low", fetch_req, 0);
        check(prefix_clr == 1'b0, "R10 prefix_clr low", prefix_clr, 0);
        check(take_int == 1'b0, "R10 take_int low", take_int, 0);
        check(cont_fetch == 1'b0, "R10 cont_fetch low", cont_fetch, 0);
        // R10: delayed enable is 0 after reset, so no take even with request
        flags_if = 1'b1;
        run_insn(0, 0, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, "R10 reset enable zero");
        // R3: no request gives continue
        run_insn(0, 0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, "R3 no request");
        // R2 + R3: queue stall then take
        run_insn(0, 3, 1'b1, 1'b0, 16'h0, 1'b0, 1'b1, "R2 R3 take after stall");
        // R4: stack-segment load shadows only its own boundary
        run_insn(1, 0, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, "R4 ss load shadow");
        run_insn(0, 1, 1'b1, 1'b0, 16'h0, 1'b0, 1'b1, "R4 shadow released");
        // R6: other segment load does not shadow
        run_insn(2, 0, 1'b1, 1'b0, 16'h0, 1'b0, 1'b1, "R6 seg load no shadow");
        // R5: enable-interrupts and back-to-back shadows
        run_insn(3, 0, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, "R5 sti shadow");
        run_insn(3, 0, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, "R5 second sti shadow");
        run_insn(1, 2, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, "R5 ss after sti shadow");
        run_insn(0, 0, 1'b1, 1'b0, 16'h0, 1'b0, 1'b1, "R5 shadow not extended");
        // R7: enable change seen only at the next boundary
        flags_if = 1'b0;
        run_insn(0, 0, 1'b1, 1'b0, 16'h0, 1'b0, 1'b1, "R7 old enable still used");
        run_insn(0, 0, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, "R7 disable applied");
        // R8 + R6: interrupt return reloads enable in the same cycle
        run_insn(4, 0, 1'b1, 1'b1, 16'h0200, 1'b0, 1'b1, "R8 R6 iret takes at once");
        flags_if = 1'b0;
        run_insn(0, 0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, "R7 clear enable");
        // R8: a non-return flags write waits for the boundary
        run_insn(0, 0, 1'b1, 1'b1, 16'h0200, 1'b0, 1'b0, "R8 other write delayed");
        run_insn(0, 0, 1'b1, 1'b0, 16'h0, 1'b0, 1'b1, "R8 other write applied");
        // R8: interrupt return clearing the enable blocks at once
        run_insn(4, 0, 1'b1, 1'b1, 16'hFDFF, 1'b0, 1'b0, "R8 iret disables at once");
        // R9: strobe while busy is ignored
        flags_if = 1'b1;
        run_insn(0, 0, 1'b0, 1'b0, 16'h0, 1'b1, 1'b0, "R9 busy strobe ignored");
        repeat (20) @(negedge clk);
        check(q_code.size() == 0, "R9 no second sequence", q_code.size(), 0);
        // R6: unused class code behaves as a non-shadowing class
        run_insn(5, 0, 1'b1, 1'b0, 16'h0, 1'b0, 1'b1, "R6 unused code no shadow");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule